// File: doc/BRIEF.md
# SD/MMC Port Error Interrupt Collector

This block sits beside the card engine of an SD/MMC serial port and turns its momentary error indications into state that software can inspect. Each of eight sources arrives as a one-cycle pulse and latches into its own sticky status bit. An enable mask decides which of those bits may raise the level-sensitive error interrupt. The first moment any enabled bit becomes pending, the block also sends a single-cycle terminate request to the attached DMA channel, so that the descriptor chain in flight halts instead of running on after a fault.

Software reads the status vector and acknowledges it by writing a mask of ones to a write-one-to-clear alias. Writing the whole pending mask acknowledges every error at once. The completion interrupt of the DMA channel is latched on a separate path. Neither the error status, the enables nor the terminate request affect it.

Top module: `sdc_err_collector`

## Requirements
- R1: After a synchronous active-high reset, status is 0x00, the enable mask is 0xFE, and err_irq_o, dma_term_o and dma_irq_o are all low.
- R2: A pulse on err_evt_i[i] sets status_o[i] from the next clock edge. The bit then stays set until it is cleared. Bit map: 0 SDIO card interrupt, 1 response error, 2 response timeout, 3 data timeout, 4 data CRC error, 5 FIFO underrun, 6 receive timeout, 7 FIFO overrun.
- R3: A status bit sets whether or not its enable is on. A pending bit whose enable is off drives neither err_irq_o nor dma_term_o. This covers the SDIO bit under the reset mask, and a response timeout seen while the bus is in 1-bit mode during card start-up.
- R4: err_irq_o is high in the cycle after status_o & enable_o is non-zero, and it stays high while that stays so. It goes low in the cycle after the masked value becomes zero.
- R5: dma_term_o pulses for exactly one cycle, in the cycle where err_irq_o rises. Further errors that arrive while err_irq_o is already high do not produce another pulse.
- R6: When clr_we_i is high, every status bit whose clr_mask_i bit is 1 clears at that edge. Bits with a 0 in the mask are unchanged.
- R7: If an error pulse and a clear of the same bit arrive at the same edge, the bit stays set.
- R8: When en_we_i is high, enable_o takes en_wdata_i at that edge. Enabling a bit that is already pending raises err_irq_o and pulses dma_term_o on the following cycle.
- R9: dma_irq_o sets on a dma_done_i pulse and clears on dma_ack_i, with set winning when both arrive together. Error pulses, error clears, enable writes and dma_term_o have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_evt_i | input | 8 | One-cycle error pulses from the card engine, one per source |
| en_we_i | input | 1 | Write strobe for the enable mask |
| en_wdata_i | input | 8 | New enable mask |
| clr_we_i | input | 1 | Write strobe for the clear alias |
| clr_mask_i | input | 8 | Ones select the status bits to clear |
| dma_done_i | input | 1 | One-cycle DMA completion pulse |
| dma_ack_i | input | 1 | Acknowledge of the DMA completion interrupt |
| status_o | output | 8 | Sticky error status |
| enable_o | output | 8 | Current enable mask |
| err_irq_o | output | 1 | Level error interrupt |
| dma_term_o | output | 1 | One-cycle terminate request to the DMA channel |
| dma_irq_o | output | 1 | Level DMA completion interrupt |

## Verification
The assertions assume that every input is synchronous to clk and settles well before each edge. They also assume that error and completion indications are sampled as single-cycle events, while the strobes may be held for any length of time. The stimulus changes inputs just after a rising edge and uses one-cycle pulses for every event. It mixes directed sequences with seeded random ones that include same-edge set/clear collisions, enable changes while errors are pending, and completion pulses that coincide with acknowledges.

// File: rtl/sdc_err_pkg.sv
package sdc_err_pkg;
  localparam int unsigned ERR_SRC_N = 8;

  // Source positions inside the status and enable vectors.
  localparam int unsigned SRC_SDIO     = 0;
  localparam int unsigned SRC_RSP_ERR  = 1;
  localparam int unsigned SRC_RSP_TMO  = 2;
  localparam int unsigned SRC_DAT_TMO  = 3;
  localparam int unsigned SRC_DAT_CRC  = 4;
  localparam int unsigned SRC_FIFO_UNF = 5;
  localparam int unsigned SRC_RX_TMO   = 6;
  localparam int unsigned SRC_FIFO_OVF = 7;

  // Out of reset every error source is enabled except the card interrupt.
  localparam logic [ERR_SRC_N-1:0] ERR_EN_DEFAULT =
    ~(ERR_SRC_N'(1) << SRC_SDIO);
endpackage

// File: rtl/sdc_err_status_bank.sv
module sdc_err_status_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] status_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;

    // Set takes priority over clear so that no pulse is lost (R7).
    always_ff @(posedge clk) begin
      if (rst)                             bit_q <= 1'b0;
      else if (set_i[i])                   bit_q <= 1'b1;
      else if (clr_we_i && clr_mask_i[i])  bit_q <= 1'b0;
    end

    assign status_o[i] = bit_q;

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> status_o[i])
      else $error("status bit %0d lost a set", i);

    assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
      (status_o[i] && !(clr_we_i && clr_mask_i[i])) |=> status_o[i])
      else $error("status bit %0d dropped without clear", i);

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
      (clr_we_i && clr_mask_i[i] && !set_i[i]) |=> !status_o[i])
      else $error("status bit %0d survived a clear", i);
  end
endmodule

// File: rtl/sdc_err_enable_reg.sv
module sdc_err_enable_reg #(
  parameter int unsigned    N        = 8,
  parameter logic [N-1:0]   EN_RESET = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst)       en_q <= EN_RESET;
    else if (we_i) en_q <= wdata_i;
  end

  assign en_o = en_q;

  assert_en_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(en_o))
    else $error("enable mask changed without a write");
endmodule

// File: rtl/sdc_err_event_gen.sv
module sdc_err_event_gen #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o,
  output logic         term_o
);
  logic pend;
  logic irq_q;
  logic term_q;

  assign pend = |(status_i & en_i);

  // Registered level interrupt plus a one-shot on its rising edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      term_q <= 1'b0;
    end else begin
      irq_q  <= pend;
      term_q <= pend & ~irq_q;
    end
  end

  assign irq_o  = irq_q;
  assign term_o = term_q;

  assert_term_single_R5: assert property (@(posedge clk) disable iff (rst)
    term_o |=> !term_o)
    else $error("terminate longer than one cycle");

  assert_term_with_irq_R5: assert property (@(posedge clk) disable iff (rst)
    term_o |-> irq_o)
    else $error("terminate without interrupt");

  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (status_i == '0) |=> !term_o)
    else $error("terminate with no pending status");
endmodule

// File: rtl/sdc_err_done_latch.sv
module sdc_err_done_latch (
  input  logic clk,
  input  logic rst,
  input  logic done_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst)         irq_q <= 1'b0;
    else if (done_i) irq_q <= 1'b1;
    else if (ack_i)  irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  assert_done_sets_R9: assert property (@(posedge clk) disable iff (rst)
    done_i |=> irq_o)
    else $error("completion pulse not latched");

  assert_done_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_i) |=> irq_o)
    else $error("completion interrupt dropped without ack");
endmodule

// File: rtl/sdc_err_collector.sv
module sdc_err_collector #(
  parameter int unsigned  N_SRC    = sdc_err_pkg::ERR_SRC_N,
  parameter logic [N_SRC-1:0] EN_RESET = sdc_err_pkg::ERR_EN_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] err_evt_i,
  input  logic             en_we_i,
  input  logic [N_SRC-1:0] en_wdata_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] clr_mask_i,
  input  logic             dma_done_i,
  input  logic             dma_ack_i,
  output logic [N_SRC-1:0] status_o,
  output logic [N_SRC-1:0] enable_o,
  output logic             err_irq_o,
  output logic             dma_term_o,
  output logic             dma_irq_o
);
  logic [N_SRC-1:0] status;
  logic [N_SRC-1:0] enable;

  sdc_err_status_bank #(.N(N_SRC)) u_status (
    .clk        (clk),
    .rst        (rst),
    .set_i      (err_evt_i),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .status_o   (status)
  );

  sdc_err_enable_reg #(.N(N_SRC), .EN_RESET(EN_RESET)) u_enable (
    .clk     (clk),
    .rst     (rst),
    .we_i    (en_we_i),
    .wdata_i (en_wdata_i),
    .en_o    (enable)
  );

  sdc_err_event_gen #(.N(N_SRC)) u_event (
    .clk      (clk),
    .rst      (rst),
    .status_i (status),
    .en_i     (enable),
    .irq_o    (err_irq_o),
    .term_o   (dma_term_o)
  );

  sdc_err_done_latch u_done (
    .clk    (clk),
    .rst    (rst),
    .done_i (dma_done_i),
    .ack_i  (dma_ack_i),
    .irq_o  (dma_irq_o)
  );

  assign status_o = status;
  assign enable_o = enable;

  assert_irq_follows_R4: assert property (@(posedge clk) disable iff (rst)
    ((status_o & enable_o) == '0) |=> !err_irq_o)
    else $error("error interrupt high with nothing pending");
endmodule

// File: tb/test_sdc_err_collector.sv
module test_sdc_err_collector;
  localparam int  N     = 8;
  localparam time CLK_P = 20ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] err_evt = '0;
  logic         en_we = 1'b0;
  logic [N-1:0] en_wdata = '0;
  logic         clr_we = 1'b0;
  logic [N-1:0] clr_mask = '0;
  logic         dma_done = 1'b0;
  logic         dma_ack = 1'b0;
  logic [N-1:0] status;
  logic [N-1:0] enable;
  logic         err_irq, dma_term, dma_irq;

  always #(CLK_P/2) clk = ~clk;

  sdc_err_collector i_sdc_err_collector (
    .clk(clk), .rst(rst), .err_evt_i(err_evt), .en_we_i(en_we),
    .en_wdata_i(en_wdata), .clr_we_i(clr_we), .clr_mask_i(clr_mask),
    .dma_done_i(dma_done), .dma_ack_i(dma_ack), .status_o(status),
    .enable_o(enable), .err_irq_o(err_irq), .dma_term_o(dma_term),
    .dma_irq_o(dma_irq)
  );

  typedef struct {
    int           due;
    logic [N-1:0] st;
    logic [N-1:0] en;
    logic         irq;
    logic         term;
    logic         dirq;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   finished = 0;

  // Reference state, from the requirements.
  logic [N-1:0] m_st = '0;
  logic [N-1:0] m_en = 8'hFE;
  logic         m_irq = 0, m_term = 0, m_dirq = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare every item that has come due.
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (status !== e.st || enable !== e.en || err_irq !== e.irq ||
          dma_term !== e.term || dma_irq !== e.dirq) begin
        n_bad++;
        $display("FAIL %s: got st=%h en=%h irq=%b term=%b dirq=%b exp st=%h en=%h irq=%b term=%b dirq=%b",
                 e.tag, status, enable, err_irq, dma_term, dma_irq,
                 e.st, e.en, e.irq, e.term, e.dirq);
      end
    end
  end

  // Driver: apply one cycle of stimulus and push the expected outcome.
  task automatic step(input logic [N-1:0] e, input logic cwe,
                      input logic [N-1:0] cm, input logic ewe,
                      input logic [N-1:0] ew, input logic dn,
                      input logic ak, input string tag);
    exp_t x;
    logic [N-1:0] n_st, n_en;
    logic         n_irq, n_term, n_dirq;
    @(posedge clk); #1;
    err_evt = e; clr_we = cwe; clr_mask = cm; en_we = ewe; en_wdata = ew;
    dma_done = dn; dma_ack = ak;
    n_st   = (m_st & ~(cwe ? cm : '0)) | e;
    n_en   = ewe ? ew : m_en;
    n_irq  = |(m_st & m_en);
    n_term = n_irq & ~m_irq;
    n_dirq = dn | (m_dirq & ~ak);
    m_st = n_st; m_en = n_en; m_irq = n_irq; m_term = n_term; m_dirq = n_dirq;
    x.due = cyc + 1; x.st = n_st; x.en = n_en; x.irq = n_irq;
    x.term = n_term; x.dirq = n_dirq; x.tag = tag;
    exp_q.push_back(x);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step('0, 0, '0, 0, '0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    n_vec++;
    if (status !== 8'h00 || enable !== 8'hFE || err_irq !== 0 ||
        dma_term !== 0 || dma_irq !== 0) begin
      n_bad++;
      $display("FAIL R1: got st=%h en=%h irq=%b term=%b dirq=%b exp st=00 en=fe irq=0 term=0 dirq=0",
               status, enable, err_irq, dma_term, dma_irq);
    end

    // R2 R4 R5: response timeout (bit 2) raises irq and one terminate
    step(8'h04, 0, '0, 0, '0, 0, 0, "R2");
    idle(4, "R5");
    // R5: a second error while irq is high gives no new terminate
    step(8'h10, 0, '0, 0, '0, 0, 0, "R5");
    idle(3, "R5");
    // R6: clear only bit 2, bit 4 stays
    step('0, 1, 8'h04, 0, '0, 0, 0, "R6");
    idle(2, "R6");
    step('0, 1, 8'h10, 0, '0, 0, 0, "R4");
    idle(3, "R4");
    // R3: SDIO bit sets, but is masked at reset
    step(8'h01, 0, '0, 0, '0, 0, 0, "R3");
    idle(3, "R3");
    // R8: enabling the pending bit raises irq and terminate
    step('0, 0, '0, 1, 8'hFF, 0, 0, "R8");
    idle(3, "R8");
    step('0, 1, 8'hFF, 0, '0, 0, 0, "R6");
    idle(2, "R6");
    // R7: collision on a pending bit and on a fresh bit
    step(8'h80, 0, '0, 0, '0, 0, 0, "R7");
    step(8'h80, 1, 8'h80, 0, '0, 0, 0, "R7");
    step(8'h40, 1, 8'hC0, 0, '0, 0, 0, "R7");
    idle(2, "R7");
    step('0, 1, 8'hFF, 0, '0, 0, 0, "R6");
    idle(2, "R6");
    // R3: all sources with all enables off
    step('0, 0, '0, 1, 8'h00, 0, 0, "R3");
    step(8'hFE, 0, '0, 0, '0, 0, 0, "R3");
    idle(3, "R3");
    step('0, 1, 8'hFF, 1, 8'hFE, 0, 0, "R6");
    idle(2, "R6");
    // R9: completion path independent of errors
    step(8'h08, 0, '0, 0, '0, 1, 0, "R9");
    idle(3, "R9");
    step('0, 1, 8'hFF, 0, '0, 0, 0, "R9");
    idle(2, "R9");
    step('0, 0, '0, 0, '0, 1, 1, "R9");
    step('0, 0, '0, 0, '0, 0, 1, "R9");
    idle(2, "R9");

    // Mixed seeded traffic
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] e, cm, ew;
      logic cwe, ewe, dn, ak;
      e   = ($urandom % 4 == 0) ? N'($urandom) & N'($urandom) : '0;
      cwe = ($urandom % 5 == 0);
      cm  = N'($urandom);
      ewe = ($urandom % 16 == 0);
      ew  = N'($urandom);
      dn  = ($urandom % 10 == 0);
      ak  = ($urandom % 6 == 0);
      step(e, cwe, cm, ewe, ew, dn, ak, "R2 R4 R5 R6 R7 R8 R9 mix");
    end
    idle(4, "R4 drain");
    @(negedge clk); @(negedge clk);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule